// File: doc/BRIEF.md
# Serial NOR Flash Bring-Up and Capacity Probe

This block takes a serial NOR flash from an unknown power-on state to a known, identified one without software help. A single start pulse launches a fixed sequence of SPI commands: it enables writes, waits for the device to become idle, writes zero to both status bytes so that no area stays write-protected, waits again, aborts anything half-finished, disables writes and finally reads the three-byte JEDEC identifier.

The identifier is decoded into the number of 4 KiB erase blocks the device holds, and that count, the raw identifier and a flag for devices whose capacity code is not in the table are presented as registered outputs. Downstream logic (an erase or programming engine, an address range checker) waits for `done` and then uses the count. The SPI wire protocol is produced by a byte shift engine instantiated inside the block; `HALF` sets the length of each half SPI clock period in system clocks.

Top module: `nor_probe_seq`

## Requirements
- R1: After reset `done`, `dev_unknown`, `dev_id` and `dev_blocks` are 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: The link runs SPI mode 0: `spi_sclk` rests low whenever `spi_cs_n` is high, each byte goes out most significant bit first, `spi_mosi` changes only while `spi_sclk` is low, and `spi_miso` is taken on the rising edge.
- R3: The first frame after a start is the single byte 0x06; it is followed by status frames of two bytes (0x05, then a dummy 0x00 during which the status arrives), repeated until a status byte with bit 0 equal to 0 is received.
- R4: Next comes the three-byte frame 0x01, 0x00, 0x00, again followed by repeated 0x05 status frames until bit 0 reads 0.
- R5: Next come two single-byte frames, first 0xFF and then 0x04.
- R6: The last frame is 0x9F followed by three dummy 0x00 bytes; the three received bytes form `dev_id` with the first in bits 23:16, the second in bits 15:8 and the third in bits 7:0.
- R7: `dev_blocks` is taken from `dev_id[15:0]`: 0x4014 gives 256, 0x4015 or 0x6015 gives 512, 0x4016 or 0x6016 gives 1024, 0x4017 gives 2048 and 0x4018 gives 4096; `dev_unknown` is then 0.
- R8: Any other value of `dev_id[15:0]` gives `dev_unknown` = 1 and `dev_blocks` = 0.
- R9: Every command has a chip-select low period of its own, and between two frames (and before the first) `spi_cs_n` stays high for at least 2*HALF system clocks.
- R10: `done` falls in the cycle after an accepted start, stays 0 while any frame is in progress, and rises once the identifier frame has ended; a start pulse while a sequence runs is ignored and does not alter the frame sequence.
- R11: While `done` is 1 and no start arrives, `dev_id`, `dev_blocks` and `dev_unknown` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that launches the bring-up sequence when idle |
| spi_miso | input | 1 | Serial data from the flash |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| dev_id | output | 24 | Identifier read from the flash |
| dev_blocks | output | BLK_W | Number of 4 KiB blocks of the identified device |
| dev_unknown | output | 1 | Capacity code not recognised |
| done | output | 1 | Sequence complete, outputs valid |

## Verification
The checker watches on every cycle the mode 0 clock rest level and data stability while the clock is high, the minimum chip-select high time before each frame, that `done` never coexists with an open frame, that an unknown device reports zero blocks, and that results hold while `done` stays up. The order and content of the frames, the number of status polls as a function of how long the flash reports busy, the assembly of the identifier and every entry of the capacity table can only be shown by the bench's scenarios, which run a behavioural flash with programmable busy time and identifier and compare each captured frame with the expected list, including a run with a stray start pulse mid-sequence.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;

  localparam int ID_W = 24;

  localparam logic [7:0] OP_WEN    = 8'h06;
  localparam logic [7:0] OP_RSTAT  = 8'h05;
  localparam logic [7:0] OP_WSTAT  = 8'h01;
  localparam logic [7:0] OP_ABORT  = 8'hFF;
  localparam logic [7:0] OP_WDIS   = 8'h04;
  localparam logic [7:0] OP_IDENT  = 8'h9F;
  localparam logic [7:0] FILL_BYTE = 8'h00;

  typedef enum logic [2:0] {
    STP_WEN,
    STP_POLL_A,
    STP_WSTAT,
    STP_POLL_B,
    STP_ABORT,
    STP_WDIS,
    STP_IDENT
  } step_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SEL,
    PH_XFER,
    PH_GAP
  } phase_t;

  function automatic logic [2:0] frame_len(step_t s);
    case (s)
      STP_POLL_A, STP_POLL_B: frame_len = 3'd2;
      STP_WSTAT:              frame_len = 3'd3;
      STP_IDENT:              frame_len = 3'd4;
      default:                frame_len = 3'd1;
    endcase
  endfunction

  function automatic logic [7:0] frame_byte(step_t s, logic [1:0] idx);
    if (idx != 2'd0) begin
      frame_byte = FILL_BYTE;
    end else begin
      case (s)
        STP_WEN:                frame_byte = OP_WEN;
        STP_POLL_A, STP_POLL_B: frame_byte = OP_RSTAT;
        STP_WSTAT:              frame_byte = OP_WSTAT;
        STP_ABORT:              frame_byte = OP_ABORT;
        STP_WDIS:               frame_byte = OP_WDIS;
        default:                frame_byte = OP_IDENT;
      endcase
    end
  endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       fin,
  output logic [7:0] rx
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic [7:0]    rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      bitn   <= 3'd0;
      sh     <= 8'd0;
      rx_sh  <= 8'd0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        cnt    <= '0;
        bitn   <= 3'd0;
        sh     <= tx;
        sclk   <= 1'b0;
        mosi   <= tx[7];
      end else if (active) begin
        if (cnt == LAST) begin
          cnt <= '0;
          if (!sclk) begin
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              fin    <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
              mosi <= sh[6];
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign rx = rx_sh;

endmodule

// File: rtl/nor_cap_decode.sv
module nor_cap_decode #(
  parameter int BLK_W = 16
) (
  input  logic [15:0]      code,
  output logic [BLK_W-1:0] blocks,
  output logic             known
);
  always_comb begin
    known  = 1'b1;
    blocks = '0;
    case (code)
      16'h4014:          blocks = BLK_W'(256);
      16'h4015, 16'h6015: blocks = BLK_W'(512);
      16'h4016, 16'h6016: blocks = BLK_W'(1024);
      16'h4017:          blocks = BLK_W'(2048);
      16'h4018:          blocks = BLK_W'(4096);
      default: begin
        known  = 1'b0;
        blocks = '0;
      end
    endcase
  end
endmodule

// File: rtl/nor_probe_fsm.sv
module nor_probe_fsm
  import nor_probe_pkg::*;
#(
  parameter int HALF  = 2,
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             eng_fin,
  input  logic [7:0]       eng_rx,
  output logic             eng_go,
  output logic [7:0]       eng_tx,
  output logic             cs_n,
  output logic [ID_W-1:0]  id_acc,
  input  logic [BLK_W-1:0] dec_blocks,
  input  logic             dec_known,
  output logic [ID_W-1:0]  id_o,
  output logic [BLK_W-1:0] blocks_o,
  output logic             unknown_o,
  output logic             done_o
);
  localparam int GAP_CYC = 2 * HALF;
  localparam int GW      = $clog2(GAP_CYC + 1) + 1;
  localparam logic [GW-1:0] GAP_END = GW'(GAP_CYC);

  phase_t      phase;
  step_t       step;
  logic [1:0]  idx;
  logic [GW-1:0] gap_cnt;
  logic        launch;
  logic [7:0]  status_q;
  logic [2:0]  len_cur;

  assign len_cur = frame_len(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      step      <= STP_WEN;
      idx       <= 2'd0;
      gap_cnt   <= '0;
      launch    <= 1'b0;
      status_q  <= 8'd0;
      id_acc    <= '0;
      eng_go    <= 1'b0;
      eng_tx    <= 8'd0;
      cs_n      <= 1'b1;
      id_o      <= '0;
      blocks_o  <= '0;
      unknown_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      eng_go <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            done_o  <= 1'b0;
            launch  <= 1'b1;
            gap_cnt <= '0;
            phase   <= PH_GAP;
          end
        end
        PH_SEL: begin
          cs_n   <= 1'b0;
          idx    <= 2'd0;
          eng_tx <= frame_byte(step, 2'd0);
          eng_go <= 1'b1;
          phase  <= PH_XFER;
        end
        PH_XFER: begin
          if (eng_fin) begin
            if (step == STP_IDENT && idx != 2'd0)
              id_acc <= {id_acc[15:0], eng_rx};
            if (idx == 2'd1)
              status_q <= eng_rx;
            if ({1'b0, idx} == len_cur - 3'd1) begin
              cs_n    <= 1'b1;
              gap_cnt <= '0;
              phase   <= PH_GAP;
            end else begin
              idx    <= idx + 2'd1;
              eng_tx <= frame_byte(step, idx + 2'd1);
              eng_go <= 1'b1;
            end
          end
        end
        default: begin
          if (gap_cnt != GAP_END) begin
            gap_cnt <= gap_cnt + GW'(1);
          end else if (launch) begin
            launch <= 1'b0;
            step   <= STP_WEN;
            phase  <= PH_SEL;
          end else begin
            phase <= PH_SEL;
            case (step)
              STP_WEN:    step <= STP_POLL_A;
              STP_POLL_A: step <= status_q[0] ? STP_POLL_A : STP_WSTAT;
              STP_WSTAT:  step <= STP_POLL_B;
              STP_POLL_B: step <= status_q[0] ? STP_POLL_B : STP_ABORT;
              STP_ABORT:  step <= STP_WDIS;
              STP_WDIS:   step <= STP_IDENT;
              default: begin
                phase     <= PH_IDLE;
                id_o      <= id_acc;
                blocks_o  <= dec_blocks;
                unknown_o <= !dec_known;
                done_o    <= 1'b1;
              end
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/nor_probe_seq.sv
module nor_probe_seq
  import nor_probe_pkg::*;
#(
  parameter int HALF  = 2,
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             spi_miso,
  output logic             spi_sclk,
  output logic             spi_mosi,
  output logic             spi_cs_n,
  output logic [23:0]      dev_id,
  output logic [BLK_W-1:0] dev_blocks,
  output logic             dev_unknown,
  output logic             done
);
  logic             go;
  logic [7:0]       tx;
  logic             fin;
  logic [7:0]       rx;
  logic [ID_W-1:0]  id_acc;
  logic [BLK_W-1:0] dec_blocks;
  logic             dec_known;

  spi_byte_engine #(.HALF(HALF)) u_eng (
    .clk  (clk),
    .rst  (rst),
    .go   (go),
    .tx   (tx),
    .miso (spi_miso),
    .sclk (spi_sclk),
    .mosi (spi_mosi),
    .fin  (fin),
    .rx   (rx)
  );

  nor_cap_decode #(.BLK_W(BLK_W)) u_dec (
    .code   (id_acc[15:0]),
    .blocks (dec_blocks),
    .known  (dec_known)
  );

  nor_probe_fsm #(.HALF(HALF), .BLK_W(BLK_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .eng_fin    (fin),
    .eng_rx     (rx),
    .eng_go     (go),
    .eng_tx     (tx),
    .cs_n       (spi_cs_n),
    .id_acc     (id_acc),
    .dec_blocks (dec_blocks),
    .dec_known  (dec_known),
    .id_o       (dev_id),
    .blocks_o   (dev_blocks),
    .unknown_o  (dev_unknown),
    .done_o     (done)
  );

endmodule

// File: rtl/nor_probe_chk.sv
module nor_probe_chk #(
  parameter int HALF  = 2,
  parameter int BLK_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             spi_sclk,
  input logic             spi_mosi,
  input logic             spi_cs_n,
  input logic [23:0]      dev_id,
  input logic [BLK_W-1:0] dev_blocks,
  input logic             dev_unknown,
  input logic             done
);
  localparam int MIN_GAP = 2 * HALF;
  localparam int HW = $clog2(MIN_GAP + 2) + 1;

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (!spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt < HW'(MIN_GAP + 1)) hi_cnt <= hi_cnt + HW'(1);
  end

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk); // R2

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R2

  AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && $past(spi_cs_n)) |-> (hi_cnt >= HW'(MIN_GAP))); // R9

  AST_NO_DONE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> !done); // R10

  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (rst)
    dev_unknown |-> (dev_blocks == '0)); // R8

  AST_KNOWN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (done && !dev_unknown) |-> (dev_blocks != '0)); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(dev_id) && $stable(dev_blocks) && $stable(dev_unknown))); // R11

endmodule

bind nor_probe_seq nor_probe_chk #(.HALF(HALF), .BLK_W(BLK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .spi_sclk    (spi_sclk),
  .spi_mosi    (spi_mosi),
  .spi_cs_n    (spi_cs_n),
  .dev_id      (dev_id),
  .dev_blocks  (dev_blocks),
  .dev_unknown (dev_unknown),
  .done        (done)
);

// File: tb/sim_nor_probe_seq.sv
`timescale 1ns/1ps
module sim_nor_probe_seq;
  localparam int HALF  = 2;
  localparam int BLK_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic spi_miso = 1'b0;
  logic spi_sclk, spi_mosi, spi_cs_n;
  logic [23:0] dev_id;
  logic [BLK_W-1:0] dev_blocks;
  logic dev_unknown, done;

  always #2 clk = ~clk;

  nor_probe_seq #(.HALF(HALF), .BLK_W(BLK_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .spi_miso(spi_miso),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .dev_id(dev_id), .dev_blocks(dev_blocks), .dev_unknown(dev_unknown), .done(done)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural flash
  int bits_in = 0;
  int nb = 0;
  logic [7:0] cur = 8'd0;
  logic [7:0] fb [4];
  int busy_left = 0;
  int busy_after_wstat = 0;
  logic [23:0] id_val = 24'd0;
  logic [39:0] got_q [$];
  logic [39:0] exp_q [$];

  function automatic logic [7:0] reply(int k);
    if (k == 0) return 8'd0;
    if (fb[0] == 8'h05) return {7'd0, busy_left > 0};
    if (fb[0] == 8'h9F) begin
      if (k == 1) return id_val[23:16];
      if (k == 2) return id_val[15:8];
      if (k == 3) return id_val[7:0];
    end
    return 8'd0;
  endfunction

  always @(negedge spi_cs_n) begin
    bits_in = 0;
    nb = 0;
    for (int i = 0; i < 4; i++) fb[i] = 8'd0;
    spi_miso = 1'b0;
  end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    cur = {cur[6:0], spi_mosi};
    bits_in++;
    if (bits_in % 8 == 0) begin
      if (nb < 4) fb[nb] = cur;
      nb++;
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    logic [7:0] r;
    r = reply(bits_in / 8);
    spi_miso = r[7 - (bits_in % 8)];
  end

  always @(posedge spi_cs_n) if (nb > 0) begin
    got_q.push_back({8'(nb), fb[0], fb[1], fb[2], fb[3]});
    if (fb[0] == 8'h05 && busy_left > 0) busy_left--;
    if (fb[0] == 8'h01) busy_left = busy_after_wstat;
    nb = 0;
  end

  // per-clock monitor
  int hi_cycles = 0;
  logic prev_cs = 1'b1;
  always @(negedge clk) if (!rst && !finished) begin
    cycles++;
    chk(!(spi_cs_n && spi_sclk), "R2 clock low while deselected", {63'd0, spi_sclk}, 64'd0);
    chk(!(!spi_cs_n && done), "R10 done low during frame", {63'd0, done}, 64'd0);
    if (prev_cs && !spi_cs_n)
      chk(hi_cycles >= 2 * HALF, "R9 deselect gap", 64'(hi_cycles), 64'(2 * HALF));
    if (spi_cs_n) hi_cycles++; else hi_cycles = 0;
    prev_cs = spi_cs_n;
  end

  function automatic logic [39:0] fr(int len, logic [7:0] b0);
    return {8'(len), b0, 24'd0};
  endfunction

  task automatic run(int pre, int post, logic [23:0] idv, logic [BLK_W-1:0] eb,
                     logic eu, bit poke, string tag);
    int wait_n;
    busy_left = pre;
    busy_after_wstat = post;
    id_val = idv;
    got_q.delete();
    exp_q.delete();
    exp_q.push_back(fr(1, 8'h06));
    for (int i = 0; i <= pre; i++) exp_q.push_back(fr(2, 8'h05));
    exp_q.push_back(fr(3, 8'h01));
    for (int i = 0; i <= post; i++) exp_q.push_back(fr(2, 8'h05));
    exp_q.push_back(fr(1, 8'hFF));
    exp_q.push_back(fr(1, 8'h04));
    exp_q.push_back(fr(4, 8'h9F));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R10 done clears after start", {63'd0, done}, 64'd0);
    wait_n = 0;
    while (!done && wait_n < 20000) begin
      @(negedge clk);
      wait_n++;
      if (poke && wait_n == 150) start = 1'b1;
      if (poke && wait_n == 151) start = 1'b0;
    end
    start = 1'b0;
    chk(done == 1'b1, {"R10 done rises ", tag}, {63'd0, done}, 64'd1);
    chk(got_q.size() == exp_q.size(), {"R3 R4 frame count ", tag},
        64'(got_q.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      string r;
      case (exp_q[i][31:24])
        8'h06, 8'h05: r = "R3";
        8'h01: r = "R4";
        8'hFF, 8'h04: r = "R5";
        default: r = "R6";
      endcase
      chk(got_q[i] == exp_q[i], {r, " frame content ", tag}, 64'(got_q[i]), 64'(exp_q[i]));
    end
    chk(dev_id == idv, {"R6 id assembly ", tag}, 64'(dev_id), 64'(idv));
    chk(dev_blocks == eb, {"R7 R8 block count ", tag}, 64'(dev_blocks), 64'(eb));
    chk(dev_unknown == eu, {"R7 R8 unknown flag ", tag}, 64'(dev_unknown), 64'(eu));
    repeat (40) @(negedge clk);
    chk(done && dev_id == idv && dev_blocks == eb && dev_unknown == eu,
        {"R11 results held ", tag}, 64'(dev_blocks), 64'(eb));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && dev_unknown == 0 && dev_id == 0 && dev_blocks == 0,
        "R1 reset outputs", 64'({done, dev_unknown, dev_id, dev_blocks}), 64'd0);
    chk(spi_cs_n == 1 && spi_sclk == 0, "R1 reset pins", {62'd0, spi_cs_n, spi_sclk}, 64'd2);
    run(2, 3, 24'hEF4017, 16'd2048, 1'b0, 1'b0, "a");
    run(0, 0, 24'hEF6015, 16'd512,  1'b0, 1'b1, "b");
    run(1, 0, 24'hEF4014, 16'd256,  1'b0, 1'b0, "c");
    run(0, 4, 24'hC84016, 16'd1024, 1'b0, 1'b0, "d");
    run(0, 0, 24'hEF6016, 16'd1024, 1'b0, 1'b0, "e");
    run(0, 1, 24'hEF4018, 16'd4096, 1'b0, 1'b0, "f");
    run(0, 0, 24'hEF4015, 16'd512,  1'b0, 1'b0, "g");
    run(0, 0, 24'hEF3014, 16'd0,    1'b1, 1'b0, "h");
    run(0, 0, 24'h1F6017, 16'd0,    1'b1, 1'b0, "i");
    run(0, 0, 24'hEF4017, 16'd2048, 1'b0, 1'b0, "j");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule